// File: doc/BRIEF.md
# Cartridge Program-ROM Bank Mapper

This block sits between a game console CPU and the program ROM of a cartridge. It converts each CPU address in the `$6000-$FFFF` range into a program-ROM address. Its four byte-wide bank registers decode at CPU addresses `$8000-$8003`, and a mode byte decodes at `$D000`. Together they choose how the upper 32 KiB of CPU space is cut into windows, and which ROM bank each window shows.

The mode byte has three fields. Bits 1:0 give the bank size. Bit 2 makes the `$E000` window switchable. Bit 7 opens an optional ROM window at `$6000`. When a window is not switchable, it returns to the power-on layout, in which the last 32 KiB of ROM appear at `$8000`. No RAM answers at `$6000-$7FFF`. The address outputs are combinational from the CPU address and the registered state. A register write takes effect from the clock edge that captures it.

Top module: `prg_bank_mapper`

## Requirements
- R1: After reset, all bank registers and the mode byte are zero, and `$8000-$FFFF` maps linearly onto the last 32 KiB of ROM.
- R2: A write with `cpu_wr` high stores `cpu_data` into bank register n only when the address is exactly `$8000+n` (n = 0..3). It stores into the mode byte only when the address is exactly `$D000`. A write to any other address changes no mapping.
- R3: With mode bits 1:0 = 00, `$8000-$FFFF` stays on the last 32 KiB of ROM whatever the bank registers hold.
- R4: With mode bits 1:0 = 01, `$8000-$BFFF` shows the 16 KiB bank given by register 1 with its bit 0 ignored. `$C000-$FFFF` shows the last 16 KiB of ROM.
- R5: With mode bits 1:0 = 10, the 8 KiB windows at `$8000`, `$A000` and `$C000` show the banks in registers 0, 1 and 2.
- R6: In both 8 KiB modes (bits 1:0 = 10 or 11), `$E000` shows the last 8 KiB of ROM when mode bit 2 is 0. When mode bit 2 is 1, it shows the bank in register 3 (mode 10) or register 0 (mode 11).
- R7: With mode bit 7 = 1, `$6000-$7FFF` selects ROM and shows the 8 KiB bank in register 3. With bit 7 = 0, `rom_sel` is low for that range.
- R8: With mode bits 1:0 = 11, the windows at `$8000`, `$A000` and `$C000` show registers 3, 2 and 1.
- R9: For CPU addresses below `$6000`, `rom_sel` is low. Whenever `rom_sel` is low, `rom_addr` is zero.
- R10: Every bank number is taken modulo 2^`BANK_W`, so a bank number beyond the ROM wraps around. The ROM address is `{bank, cpu_addr[12:0]}`.
- R11: Mode bits 6:3 have no effect on the program mapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, sampled on the rising clock edge |
| rom_addr | output | BANK_W+13 | Program-ROM byte address |
| rom_sel | output | 1 | High when the access targets program ROM |

## Verification
The bench builds the mapper with `BANK_W = 4`, a 128 KiB ROM of sixteen 8 KiB banks. At that size the fixed windows land on banks 12 to 15. A register value of `0x13` must wrap to bank 3, which makes the masking rule visible at the ROM address. Each mode is entered with the same register contents, so the normal, reversed and 16 KiB orderings can be told apart bank by bank. Non-zero address offsets confirm that the low 13 bits pass straight through.

// File: rtl/prg_bank_mapper.sv
module prg_bank_mapper #(
  parameter int BANK_W = 5,
  localparam int AW = BANK_W + 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   cpu_addr,
  input  logic [7:0]    cpu_data,
  input  logic          cpu_wr,
  output logic [AW-1:0] rom_addr,
  output logic          rom_sel
);

  localparam logic [BANK_W-1:0] LAST = '1;

  logic [7:0] bank_q [4];
  logic [7:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) bank_q[i] <= '0;
      mode_q <= '0;
    end else if (cpu_wr) begin
      if (cpu_addr[15:2] == 14'h2000) bank_q[cpu_addr[1:0]] <= cpu_data;
      if (cpu_addr == 16'hD000) mode_q <= cpu_data;
    end
  end

  wire [1:0] win  = cpu_addr[14:13];
  wire [1:0] size = mode_q[1:0];
  wire       pin_e = mode_q[2];
  wire       low_win = cpu_addr[15:13] == 3'b011 && mode_q[7];

  logic [BANK_W-1:0] bank;
  logic              sel;

  always_comb begin
    bank = '0;
    sel  = 1'b0;
    if (cpu_addr[15]) begin
      sel = 1'b1;
      case (size)
        2'b01: bank = win[1] ? LAST - BANK_W'(1) + BANK_W'(win[0])
                             : {bank_q[1][BANK_W-1:1], win[0]};
        2'b10: bank = (win == 2'd3 && !pin_e) ? LAST : bank_q[win][BANK_W-1:0];
        2'b11: bank = (win == 2'd3 && !pin_e) ? LAST : bank_q[~win][BANK_W-1:0];
        default: bank = LAST - BANK_W'(3) + BANK_W'(win);
      endcase
    end else if (low_win) begin
      sel  = 1'b1;
      bank = bank_q[3][BANK_W-1:0];
    end
  end

  assign rom_sel  = sel;
  assign rom_addr = sel ? {bank, cpu_addr[12:0]} : '0;

  a_r2_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == 16'h8000) |=> bank_q[0] == $past(cpu_data));
  a_r3_fixed_last32: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b00 && cpu_addr[15]) |-> rom_addr[AW-1:15] == '1);
  a_r4_top16_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (size == 2'b01 && cpu_addr[15:14] == 2'b11) |-> rom_addr[AW-1:14] == '1);
  a_r7_no_ram: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] == 3'b011 && !mode_q[7]) |-> !rom_sel);
  a_r9_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:13] < 3'b011) |-> (!rom_sel && rom_addr == '0));
  a_r10_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> rom_addr[12:0] == cpu_addr[12:0]);

endmodule

// File: tb/tb_prg_bank_mapper.sv
module tb_prg_bank_mapper;
  localparam int BW = 4;
  localparam int AW = BW + 13;

  logic clk = 0, rst_n = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_data = '0;
  logic [AW-1:0] rom_addr;
  logic rom_sel;
  int checks = 0, fails = 0;
  bit done = 0;

  prg_bank_mapper #(.BANK_W(BW)) dut (.*);

  always #10 clk = ~clk;

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic chk(input logic [15:0] a, input bit esel, input int ebank, input string req);
    logic [AW-1:0] exp;
    @(negedge clk);
    cpu_addr = a;
    #5;
    exp = esel ? AW'((ebank % 16) * 8192 + int'(a[12:0])) : '0;
    checks++;
    if (rom_sel !== esel || rom_addr !== exp) begin
      fails++;
      $display("FAIL %s addr=%h: sel=%b rom=%h expected sel=%b rom=%h", req, a, rom_sel, rom_addr, esel, exp);
    end
  endtask

  task automatic t_reset;
    chk(16'h8000, 1, 12, "R1"); chk(16'hFFFF, 1, 15, "R1");
    chk(16'h6000, 0, 0, "R1"); chk(16'h4020, 0, 0, "R9");
  endtask

  task automatic t_fixed;
    wr(16'h8000, 1); wr(16'h8001, 2); wr(16'h8002, 3); wr(16'h8003, 4);
    chk(16'hA123, 1, 13, "R3"); chk(16'hC000, 1, 14, "R3");
  endtask

  task automatic t_eight;
    wr(16'hD000, 8'h02);
    chk(16'h8123, 1, 1, "R5"); chk(16'hA000, 1, 2, "R5");
    chk(16'hC000, 1, 3, "R5"); chk(16'hE000, 1, 15, "R6");
    wr(16'hD000, 8'h06);
    chk(16'hE456, 1, 4, "R6");
  endtask

  task automatic t_decode;
    wr(16'h8004, 9); wr(16'h9000, 9); wr(16'h0000, 9); wr(16'hD001, 8'h00); wr(16'hD004, 8'h00);
    chk(16'h8000, 1, 1, "R2"); chk(16'hA000, 1, 2, "R2");
    chk(16'hC000, 1, 3, "R2"); chk(16'hE000, 1, 4, "R2");
  endtask

  task automatic t_sixteen;
    wr(16'hD000, 8'h01);
    chk(16'h8000, 1, 2, "R4"); chk(16'hA000, 1, 3, "R4");
    wr(16'h8001, 5);
    chk(16'h8010, 1, 4, "R4"); chk(16'hA010, 1, 5, "R4");
    chk(16'hC000, 1, 14, "R4"); chk(16'hE000, 1, 15, "R4");
  endtask

  task automatic t_reverse;
    wr(16'hD000, 8'h07);
    chk(16'h8000, 1, 4, "R8"); chk(16'hA000, 1, 3, "R8");
    chk(16'hC000, 1, 5, "R8"); chk(16'hE000, 1, 1, "R6");
    wr(16'hD000, 8'h03);
    chk(16'hE000, 1, 15, "R6");
  endtask

  task automatic t_low;
    wr(16'hD000, 8'h82);
    chk(16'h6000, 1, 4, "R7"); chk(16'h7FFF, 1, 4, "R7");
    chk(16'h5000, 0, 0, "R9");
    wr(16'hD000, 8'h02);
    chk(16'h6ABC, 0, 0, "R7");
  endtask

  task automatic t_wrap;
    wr(16'h8000, 8'h13);
    chk(16'h8001, 1, 3, "R10");
    wr(16'hD000, 8'h7A);
    chk(16'h8000, 1, 3, "R11"); chk(16'hE000, 1, 15, "R11");
    chk(16'h6000, 0, 0, "R11");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_fixed; t_eight; t_decode; t_sixteen; t_reverse; t_low; t_wrap;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule